// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds one atomic-access reservation for a single hardware context. A load-linked access records the 16-byte granule of its physical address and arms the reservation. A later store-conditional is granted only if the reservation is still armed and its address falls in the same granule. Every cacheable store-conditional consumes the reservation, whether it is granted or refused. An external invalidate that hits the reserved granule disarms the reservation before the store arrives.

Uncacheable store-conditionals skip the check. They always go to memory and report a "no result" code, so the core does not write a status register for them. A consecutive-failure counter watches for livelock. It raises a one-cycle warning on every tenth refusal in a row and latches a fatal alarm when the run reaches 5000. The memory system and the coherence fabric sit outside the block. The invalidate port stands in for snoop traffic.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked request records its address with the low 4 bits cleared and arms the reservation, so a later store to any byte of that 16-byte granule matches.
- R2: A cacheable store-conditional with an armed reservation and a matching granule reports code 2'b01 (granted), raises `mem_fwd`, and disarms the reservation.
- R3: A cacheable store-conditional with the reservation disarmed, or with a different granule, reports code 2'b10 (refused), keeps `mem_fwd` low, and disarms the reservation.
- R4: An uncacheable store-conditional reports code 2'b11 (no result) with `mem_fwd` high. It changes neither the reservation nor the failure counter.
- R5: `res_valid`, `res_code` and `mem_fwd` appear exactly one cycle after the `sc_valid` strobe. Otherwise `res_valid` is low and `res_code` is 2'b00.
- R6: Each refused store-conditional adds one to the consecutive-failure counter. A granted one returns the counter to zero.
- R7: `warn_pulse` is high for one cycle, in the same cycle as the result, when a refusal brings the counter to a nonzero multiple of 10.
- R8: When the counter reaches 5000, `deadlock_alarm` sets and stays set until reset. The counter then holds at 5000, and further refusals raise no warning.
- R9: An invalidate whose granule matches the reserved granule disarms the reservation. An invalidate to another granule has no effect.
- R10: A new load-linked request replaces any earlier reservation. If a load-linked and an invalidate arrive in the same cycle, the load-linked wins.
- R11: Synchronous active-high reset disarms the reservation and clears the stored address, the counter, the alarm and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked request strobe |
| ll_addr | input | ADDR_W | Load-linked physical address |
| sc_valid | input | 1 | Store-conditional request strobe |
| sc_addr | input | ADDR_W | Store-conditional physical address |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| inv_valid | input | 1 | Invalidate (snoop) strobe |
| inv_addr | input | ADDR_W | Invalidated physical address |
| res_valid | output | 1 | Result valid, one cycle after `sc_valid` |
| res_code | output | 2 | 00 idle, 01 granted, 10 refused, 11 no result |
| mem_fwd | output | 1 | Forward the store to memory |
| warn_pulse | output | 1 | Livelock warning, one cycle |
| deadlock_alarm | output | 1 | Sticky deadlock alarm |

## Verification
The hardest condition to reach from the ports is the deadlock alarm. It needs 5000 refusals in a row with no grant between them. The bench gets there by issuing store-conditionals back to back with no reservation armed, after one grant has cleared the counter. A scoreboard in the bench tracks the count and predicts each warning and the exact refusal on which the alarm sets. After the alarm, further refusals and then a grant confirm that the counter saturates and that the alarm stays set.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'b00,
    SC_OK    = 2'b01,
    SC_FAIL  = 2'b10,
    SC_NORES = 2'b11
  } sc_code_e;

endpackage

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_consume,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              sc_hit
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

  function automatic logic [ADDR_W-1:0] granule_of(input logic [ADDR_W-1:0] a);
    return a & GRAN_MASK;
  endfunction

  logic              armed_q;
  logic [ADDR_W-1:0] base_q;
  logic              inv_hit;

  assign inv_hit = inv_valid && (granule_of(inv_addr) == base_q);
  assign sc_hit  = armed_q && (granule_of(sc_addr) == base_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      base_q  <= '0;
    end else if (ll_valid) begin
      armed_q <= 1'b1;
      base_q  <= granule_of(ll_addr);
    end else if (sc_consume || inv_hit) begin
      armed_q <= 1'b0;
    end
  end

  // R10: a load-linked always leaves the reservation armed
  a_r10_ll_arms: assert property (@(posedge clk) disable iff (rst)
    ll_valid |=> armed_q);

  // R3 / R2: a cacheable store-conditional without a new load-linked consumes the reservation
  a_r3_sc_consumes: assert property (@(posedge clk) disable iff (rst)
    (sc_consume && !ll_valid) |=> !armed_q);

  // R9: an invalidate to another granule leaves the armed state untouched
  a_r9_foreign_inv: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !ll_valid && !sc_consume && granule_of(inv_addr) != base_q) |=> $stable(armed_q));

endmodule

// File: rtl/llsc_fail_track.sv
module llsc_fail_track #(
  parameter int CNT_W      = 13,
  parameter int FAIL_LIMIT = 5000,
  parameter int WARN_EVERY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_evt,
  input  logic pass_evt,
  output logic warn_pulse,
  output logic alarm
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(FAIL_LIMIT);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == LIMIT_V) ? c : c + CNT_W'(1);
  endfunction

  function automatic logic warn_due(input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] nxt);
    return (nxt != cur) && ((int'(nxt) % WARN_EVERY) == 0);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = bump(cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      warn_pulse <= 1'b0;
      alarm      <= 1'b0;
    end else begin
      warn_pulse <= 1'b0;
      if (pass_evt) begin
        cnt_q <= '0;
      end else if (fail_evt) begin
        cnt_q      <= cnt_nxt;
        warn_pulse <= warn_due(cnt_q, cnt_nxt);
        if (cnt_nxt == LIMIT_V) alarm <= 1'b1;
      end
    end
  end

  // R8: the alarm never drops once set
  a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
    alarm |=> alarm);

  // R8: the counter never exceeds the limit
  a_r8_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT_V);

  // R7: warnings are isolated single-cycle pulses
  a_r7_warn_single: assert property (@(posedge clk) disable iff (rst)
    warn_pulse |=> !warn_pulse);

  // R6: a grant returns the run length to zero
  a_r6_pass_clears: assert property (@(posedge clk) disable iff (rst)
    pass_evt |=> (cnt_q == '0));

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int ADDR_W     = 32,
  parameter int GRAN_BITS  = 4,
  parameter int CNT_W      = 13,
  parameter int FAIL_LIMIT = 5000,
  parameter int WARN_EVERY = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_uncached,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic              mem_fwd,
  output logic              warn_pulse,
  output logic              deadlock_alarm
);

  import llsc_pkg::*;

  logic     sc_cached;
  logic     sc_hit;
  logic     pass_evt;
  logic     fail_evt;
  sc_code_e code_d;

  assign sc_cached = sc_valid && !sc_uncached;
  assign pass_evt  = sc_cached && sc_hit;
  assign fail_evt  = sc_cached && !sc_hit;

  always_comb begin
    if (!sc_valid)        code_d = SC_IDLE;
    else if (sc_uncached) code_d = SC_NORES;
    else if (sc_hit)      code_d = SC_OK;
    else                  code_d = SC_FAIL;
  end

  llsc_resv_reg #(
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS)
  ) u_resv (
    .clk        (clk),
    .rst        (rst),
    .ll_valid   (ll_valid),
    .ll_addr    (ll_addr),
    .sc_consume (sc_cached),
    .sc_addr    (sc_addr),
    .inv_valid  (inv_valid),
    .inv_addr   (inv_addr),
    .sc_hit     (sc_hit)
  );

  llsc_fail_track #(
    .CNT_W      (CNT_W),
    .FAIL_LIMIT (FAIL_LIMIT),
    .WARN_EVERY (WARN_EVERY)
  ) u_fail (
    .clk        (clk),
    .rst        (rst),
    .fail_evt   (fail_evt),
    .pass_evt   (pass_evt),
    .warn_pulse (warn_pulse),
    .alarm      (deadlock_alarm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_code  <= SC_IDLE;
      mem_fwd   <= 1'b0;
    end else begin
      res_valid <= sc_valid;
      res_code  <= code_d;
      mem_fwd   <= sc_valid && (sc_uncached || sc_hit);
    end
  end

  // R5: every strobe yields a result on the next cycle
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    sc_valid |=> res_valid);

  // R5: no result without a strobe
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !sc_valid |=> (!res_valid && res_code == SC_IDLE));

  // R3: a refused store never reaches memory
  a_r3_fail_blocks: assert property (@(posedge clk) disable iff (rst)
    (res_code == SC_FAIL) |-> !mem_fwd);

  // R4: an uncacheable store always goes to memory
  a_r4_nores_fwd: assert property (@(posedge clk) disable iff (rst)
    (res_code == SC_NORES) |-> mem_fwd);

  // R7: warnings only accompany refusals
  a_r7_warn_on_fail: assert property (@(posedge clk) disable iff (rst)
    warn_pulse |-> (res_valid && res_code == SC_FAIL));

endmodule

// File: tb/test_llsc_resv_monitor.sv
module test_llsc_resv_monitor;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          ll_valid, sc_valid, sc_uncached, inv_valid;
  logic [AW-1:0] ll_addr, sc_addr, inv_addr;
  logic          res_valid, mem_fwd, warn_pulse, deadlock_alarm;
  logic [1:0]    res_code;

  int checks = 0;
  int errors = 0;

  // bench scoreboard
  bit            m_armed;
  logic [AW-5:0] m_gran;
  int            m_cnt;
  bit            m_alarm;

  always #4 clk = ~clk;

  llsc_resv_monitor i_llsc_resv_monitor (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .res_valid(res_valid), .res_code(res_code), .mem_fwd(mem_fwd),
    .warn_pulse(warn_pulse), .deadlock_alarm(deadlock_alarm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_armed = 0; m_gran = '0; m_cnt = 0; m_alarm = 0;
  endtask

  task automatic idle_inputs();
    ll_valid = 0; sc_valid = 0; sc_uncached = 0; inv_valid = 0;
    ll_addr = '0; sc_addr = '0; inv_addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic ll_op(input logic [AW-1:0] a, input bit with_inv, input logic [AW-1:0] ia);
    @(negedge clk);
    ll_valid = 1; ll_addr = a;
    inv_valid = with_inv; inv_addr = ia;
    @(negedge clk);
    idle_inputs();
    m_armed = 1; m_gran = a[AW-1:4];
  endtask

  task automatic inv_op(input logic [AW-1:0] a);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    idle_inputs();
    if (a[AW-1:4] == m_gran) m_armed = 0;
  endtask

  // one store-conditional, predicted by the scoreboard, checked one cycle later
  task automatic sc_op(input logic [AW-1:0] a, input bit unc, input string tag, input bit quiet);
    int  e_code;
    bit  e_fwd, e_warn;
    @(negedge clk);
    if (!quiet) begin
      chk({tag, " R5 idle res_valid"}, int'(res_valid), 0);
      chk({tag, " R5 idle res_code"}, int'(res_code), 0);
    end
    sc_valid = 1; sc_addr = a; sc_uncached = unc;
    e_warn = 0;
    if (unc) begin
      e_code = 3; e_fwd = 1;
    end else if (m_armed && a[AW-1:4] == m_gran) begin
      e_code = 1; e_fwd = 1; m_armed = 0; m_cnt = 0;
    end else begin
      e_code = 2; e_fwd = 0; m_armed = 0;
      if (m_cnt < 5000) begin
        m_cnt++;
        e_warn = (m_cnt % 10 == 0);
        if (m_cnt == 5000) m_alarm = 1;
      end
    end
    @(negedge clk);
    chk({tag, " R5 res_valid"}, int'(res_valid), 1);
    chk({tag, " R2/R3/R4 res_code"}, int'(res_code), e_code);
    chk({tag, " R2/R3/R4 mem_fwd"}, int'(mem_fwd), int'(e_fwd));
    chk({tag, " R7 warn_pulse"}, int'(warn_pulse), int'(e_warn));
    chk({tag, " R8 alarm"}, int'(deadlock_alarm), int'(m_alarm));
    idle_inputs();
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R11 reset res_valid", int'(res_valid), 0);
    chk("R11 reset res_code", int'(res_code), 0);
    chk("R11 reset mem_fwd", int'(mem_fwd), 0);
    chk("R11 reset warn", int'(warn_pulse), 0);
    chk("R11 reset alarm", int'(deadlock_alarm), 0);
    sc_op(32'h0000_0000, 0, "R11 unarmed after reset", 0);
  endtask

  task automatic t_basic_grant();
    ll_op(32'h1000_0004, 0, '0);
    sc_op(32'h1000_000C, 0, "R1 R2 same granule grant", 0);
    sc_op(32'h1000_000C, 0, "R2 reservation consumed", 0);
  endtask

  task automatic t_mismatch();
    ll_op(32'h2000_0000, 0, '0);
    sc_op(32'h2000_0010, 0, "R3 granule mismatch", 0);
    sc_op(32'h2000_0000, 0, "R3 cleared by refusal", 0);
  endtask

  task automatic t_uncached();
    ll_op(32'h3000_0020, 0, '0);
    sc_op(32'h9999_0000, 1, "R4 uncached no result", 0);
    sc_op(32'h3000_002F, 0, "R4 reservation kept", 0);
  endtask

  task automatic t_invalidate();
    ll_op(32'h4000_0040, 0, '0);
    inv_op(32'h4000_0050);
    sc_op(32'h4000_0048, 0, "R9 foreign invalidate ignored", 0);
    ll_op(32'h4000_0040, 0, '0);
    inv_op(32'h4000_004C);
    sc_op(32'h4000_0040, 0, "R9 matching invalidate clears", 0);
  endtask

  task automatic t_replace();
    ll_op(32'h5000_0000, 1, 32'h5000_0008);
    sc_op(32'h5000_0004, 0, "R10 ll beats invalidate", 0);
    ll_op(32'h6000_0000, 0, '0);
    ll_op(32'h7000_0000, 0, '0);
    sc_op(32'h7000_0000, 0, "R10 newer reservation", 0);
    ll_op(32'h6000_0000, 0, '0);
    ll_op(32'h7000_0000, 0, '0);
    sc_op(32'h6000_0000, 0, "R10 older reservation gone", 0);
  endtask

  task automatic t_warn_run();
    ll_op(32'h8000_0000, 0, '0);
    sc_op(32'h8000_0000, 0, "R6 grant zeroes count", 0);
    for (int i = 0; i < 25; i++) sc_op(32'h8000_0100, 0, "R6 R7 refusal run", 0);
    ll_op(32'h8000_0000, 0, '0);
    sc_op(32'h8000_0000, 0, "R6 grant resets run", 0);
    for (int i = 0; i < 10; i++) sc_op(32'h8000_0100, 0, "R6 R7 tenth after reset", 0);
    chk("R6 scoreboard count", m_cnt, 10);
  endtask

  task automatic t_alarm();
    ll_op(32'hA000_0000, 0, '0);
    sc_op(32'hA000_0000, 0, "R8 start clean", 0);
    for (int i = 0; i < 5003; i++) sc_op(32'hA000_0100, 0, "R8 long run", 1);
    chk("R8 alarm reached", int'(deadlock_alarm), 1);
    ll_op(32'hA000_0000, 0, '0);
    sc_op(32'hA000_0000, 0, "R8 alarm survives grant", 0);
    for (int i = 0; i < 10; i++) sc_op(32'hA000_0100, 0, "R8 new run after alarm", 1);
  endtask

  task automatic t_reset_clears();
    ll_op(32'hB000_0000, 0, '0);
    do_reset();
    @(negedge clk);
    chk("R11 alarm cleared", int'(deadlock_alarm), 0);
    chk("R11 res_valid cleared", int'(res_valid), 0);
    sc_op(32'hB000_0000, 0, "R11 reservation dropped", 0);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    model_reset();
    do_reset();
    t_reset_state();
    t_basic_grant();
    t_mismatch();
    t_uncached();
    t_invalidate();
    t_replace();
    t_warn_run();
    t_alarm();
    t_reset_clears();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule